// File: doc/BRIEF.md
# Quad-Pumped Inverting Data Bus Port

This block is the datapath of one agent on a shared 64-bit data bus. The bus is active low and source synchronous, and it moves four 64-bit sub-phases in each common-clock period. The model runs on a single clock at the sub-phase rate, so one common-clock period, called a frame here, lasts four cycles. A free-running slot counter marks the four cycles of a frame.

On the transmit side, the core offers four words in the last slot of a frame. In the frame that follows, the block drives them one per cycle. For every sub-phase, each 16-bit group is checked on its own. The group is sent inverted, with its inversion flag pulled low, when sending it plainly would put more than half of its lines electrically low. The ready line marks each valid sub-phase. The busy line covers the transfer and is held for one extra cycle after it.

On the receive side, each strobe edge is modelled as a capture enable. A capture counts only while ready is low. The receiver undoes the inversion for each group, and after the fourth qualified capture it presents the four restored words with a one-cycle valid pulse.

Top module: `qp_bus_port`

## Requirements
- R1: Group g is data bits [16g+15:16g] and pairs with inversion flag bit g. For example, the word 0x0000_FFFF_01FF_00FF is driven with flags 4'b1001.
- R2: Every line is active low. A group whose flag is high (not inverted) is driven as the bitwise complement of its logical value.
- R3: A group with 9 or more logical ones is driven with its flag low, and its lines carry the logical value unchanged. An all-ones group therefore drives no line low.
- R4: A group with exactly 8 logical ones is not inverted.
- R5: No driven group ever has more than 8 lines electrically low.
- R6: tx_load is sampled only in slot 3 and ignored in every other slot. Word k, taken from bits [64k+63:64k] of tx_words, is driven in the k-th cycle after the load, and those cycles show slots 0 to 3.
- R7: bus_ready_n is low in exactly the four cycles that carry a frame. bus_busy_n is low in those cycles and in the one cycle after the last of them. When idle, all data and flag lines are high.
- R8: The receiver restores each group as the complement of its lines when the flag is high, and as the lines themselves when the flag is low.
- R9: rx_valid pulses for one cycle, in the cycle after the fourth qualified capture. rx_words then holds capture k in bits [64k+63:64k].
- R10: A capture with rx_ready_n high, or with rx_cap_en low, is ignored and does not advance the capture count.
- R11: While reset is held, all bus outputs are high, tx_slot is 0 and rx_valid is 0.
- R12: Back-to-back frames keep bus_busy_n low continuously, and the flags of each sub-phase depend only on that sub-phase's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-phase rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_load | input | 1 | Offer a frame; taken in slot 3 only |
| tx_words | input | 256 | Four logical words; word k at bits [64k+63:64k] |
| tx_slot | output | 2 | Current slot of the frame, 0 to 3 |
| bus_data_n | output | 64 | Driven data lines, active low |
| bus_inv_n | output | 4 | Driven inversion flags, one per group, active low |
| bus_ready_n | output | 1 | Sub-phase valid, active low |
| bus_busy_n | output | 1 | Data bus owned, active low |
| rx_cap_en | input | 1 | Strobe edge model: capture in this cycle |
| rx_data_n | input | 64 | Received data lines |
| rx_inv_n | input | 4 | Received inversion flags |
| rx_ready_n | input | 1 | Received sub-phase valid, active low |
| rx_valid | output | 1 | Restored frame present for one cycle |
| rx_words | output | 256 | Restored words; capture k at bits [64k+63:64k] |

## Verification
A bad slot counter or word-hold register shows up in the very next cycle as the wrong word, or as ready and busy lines out of alignment with the slot output. A wrong inversion decision appears on the same cycle's lines and flags, and it survives the round trip as a mismatch in the restored words four cycles later. A receive counter that drifts, or that counts unqualified edges, moves the valid pulse away from the expected cycle, and the loopback model catches this at the first frame. The bench loops transmit into receive, compares every output on every cycle, and drives directed receive sequences with skipped and disabled captures.

// File: rtl/qp_pkg.sv
package qp_pkg;
    localparam int unsigned QP_DATA_W = 64;
    localparam int unsigned QP_GRP_W  = 16;
    localparam int unsigned QP_SUBS   = 4;

    function automatic int unsigned qp_groups(input int unsigned data_w, input int unsigned grp_w);
        return data_w / grp_w;
    endfunction
endpackage

// File: rtl/qp_grp_enc.sv
module qp_grp_enc #(
    parameter int unsigned GRP_W = qp_pkg::QP_GRP_W
) (
    input  logic [GRP_W-1:0] word_i,
    output logic [GRP_W-1:0] pins_n_o,
    output logic             flag_n_o
);
    localparam int unsigned CNT_W = $clog2(GRP_W + 1);
    localparam int unsigned HALF  = GRP_W / 2;

    logic [CNT_W-1:0] lows;
    logic             flip;

    // a logical one is an electrical low, so ones count the low lines
    always_comb begin
        lows = '0;
        for (int i = 0; i < GRP_W; i++) begin
            lows = lows + CNT_W'(word_i[i]);
        end
        flip     = (lows > CNT_W'(HALF));
        pins_n_o = flip ? word_i : ~word_i;
        flag_n_o = ~flip;
    end
endmodule

// File: rtl/qp_tx.sv
module qp_tx #(
    parameter int unsigned DATA_W = qp_pkg::QP_DATA_W,
    parameter int unsigned GRP_W  = qp_pkg::QP_GRP_W,
    parameter int unsigned SUBS   = qp_pkg::QP_SUBS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [SUBS*DATA_W-1:0]   words_i,
    output logic [$clog2(SUBS)-1:0]  slot_o,
    output logic [DATA_W-1:0]        data_n_o,
    output logic [DATA_W/GRP_W-1:0]  inv_n_o,
    output logic                     ready_n_o,
    output logic                     busy_n_o
);
    localparam int unsigned NG   = qp_pkg::qp_groups(DATA_W, GRP_W);
    localparam int unsigned PH_W = $clog2(SUBS);
    localparam int unsigned HALF = GRP_W / 2;
    localparam logic [PH_W-1:0] LAST = PH_W'(SUBS - 1);

    typedef struct packed {
        logic [PH_W-1:0]        ph;
        logic                   act;
        logic                   busy;
        logic [SUBS*DATA_W-1:0] hold;
        logic [DATA_W-1:0]      pins_n;
        logic [NG-1:0]          flags_n;
    } tx_st_t;

    tx_st_t            st_d, st_q;
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] enc_pins;
    logic [NG-1:0]     enc_flags;
    logic              nxt_act;

    for (genvar g = 0; g < NG; g++) begin : g_enc
        qp_grp_enc #(.GRP_W(GRP_W)) u_enc (
            .word_i   (sel_word[g*GRP_W +: GRP_W]),
            .pins_n_o (enc_pins[g*GRP_W +: GRP_W]),
            .flag_n_o (enc_flags[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (st_q.ph == LAST) begin
            st_d.ph  = '0;
            nxt_act  = load_i;
            sel_word = words_i[DATA_W-1:0];
            if (load_i) begin
                st_d.hold = words_i;
            end
        end else begin
            st_d.ph  = st_q.ph + 1'b1;
            nxt_act  = st_q.act;
            sel_word = st_q.hold[(int'(st_q.ph) + 1)*DATA_W +: DATA_W];
        end
        st_d.act     = nxt_act;
        st_d.busy    = nxt_act | st_q.act;
        st_d.pins_n  = nxt_act ? enc_pins  : '1;
        st_d.flags_n = nxt_act ? enc_flags : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph      <= '0;
            st_q.act     <= 1'b0;
            st_q.busy    <= 1'b0;
            st_q.hold    <= '0;
            st_q.pins_n  <= '1;
            st_q.flags_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o    = st_q.ph;
    assign data_n_o  = st_q.pins_n;
    assign inv_n_o   = st_q.flags_n;
    assign ready_n_o = ~st_q.act;
    assign busy_n_o  = ~st_q.busy;

    for (genvar g = 0; g < NG; g++) begin : g_chk
        p_low_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(~st_q.pins_n[g*GRP_W +: GRP_W]) <= HALF);
        p_flag_heavy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.flags_n[g] |-> ($countones(st_q.pins_n[g*GRP_W +: GRP_W]) > HALF));
    end

    p_ready_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_n_o |-> !busy_n_o);
    p_busy_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n_o) |-> !busy_n_o);
    p_frame_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n_o) |-> (slot_o == '0));
endmodule

// File: rtl/qp_rx.sv
module qp_rx #(
    parameter int unsigned DATA_W = qp_pkg::QP_DATA_W,
    parameter int unsigned GRP_W  = qp_pkg::QP_GRP_W,
    parameter int unsigned SUBS   = qp_pkg::QP_SUBS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en_i,
    input  logic [DATA_W-1:0]        data_n_i,
    input  logic [DATA_W/GRP_W-1:0]  inv_n_i,
    input  logic                     ready_n_i,
    output logic                     valid_o,
    output logic [SUBS*DATA_W-1:0]   words_o
);
    localparam int unsigned NG   = qp_pkg::qp_groups(DATA_W, GRP_W);
    localparam int unsigned PH_W = $clog2(SUBS);
    localparam logic [PH_W-1:0] LAST = PH_W'(SUBS - 1);

    typedef struct packed {
        logic [PH_W-1:0]        cnt;
        logic                   valid;
        logic [SUBS*DATA_W-1:0] hold;
        logic [SUBS*DATA_W-1:0] out;
    } rx_st_t;

    rx_st_t            st_d, st_q;
    logic [DATA_W-1:0] restored;
    logic              take;

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            restored[g*GRP_W +: GRP_W] = inv_n_i[g] ? ~data_n_i[g*GRP_W +: GRP_W]
                                                    :  data_n_i[g*GRP_W +: GRP_W];
        end
        take       = cap_en_i & ~ready_n_i;
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (take) begin
            st_d.hold[int'(st_q.cnt)*DATA_W +: DATA_W] = restored;
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                st_d.valid = 1'b1;
                st_d.out   = st_d.hold;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign words_o = st_q.out;

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    p_ignore_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i || ready_n_i) |=> ($stable(st_q.cnt) && !valid_o));
endmodule

// File: rtl/qp_bus_port.sv
module qp_bus_port #(
    parameter int unsigned DATA_W = qp_pkg::QP_DATA_W,
    parameter int unsigned GRP_W  = qp_pkg::QP_GRP_W,
    parameter int unsigned SUBS   = qp_pkg::QP_SUBS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_load,
    input  logic [SUBS*DATA_W-1:0]   tx_words,
    output logic [$clog2(SUBS)-1:0]  tx_slot,
    output logic [DATA_W-1:0]        bus_data_n,
    output logic [DATA_W/GRP_W-1:0]  bus_inv_n,
    output logic                     bus_ready_n,
    output logic                     bus_busy_n,
    input  logic                     rx_cap_en,
    input  logic [DATA_W-1:0]        rx_data_n,
    input  logic [DATA_W/GRP_W-1:0]  rx_inv_n,
    input  logic                     rx_ready_n,
    output logic                     rx_valid,
    output logic [SUBS*DATA_W-1:0]   rx_words
);
    qp_tx #(.DATA_W(DATA_W), .GRP_W(GRP_W), .SUBS(SUBS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tx_load),
        .words_i   (tx_words),
        .slot_o    (tx_slot),
        .data_n_o  (bus_data_n),
        .inv_n_o   (bus_inv_n),
        .ready_n_o (bus_ready_n),
        .busy_n_o  (bus_busy_n)
    );

    qp_rx #(.DATA_W(DATA_W), .GRP_W(GRP_W), .SUBS(SUBS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en_i  (rx_cap_en),
        .data_n_i  (rx_data_n),
        .inv_n_i   (rx_inv_n),
        .ready_n_i (rx_ready_n),
        .valid_o   (rx_valid),
        .words_o   (rx_words)
    );
endmodule

// File: tb/test_qp_bus_port.sv
`timescale 1ns/1ps
module test_qp_bus_port;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_load = 1'b0;
    logic [255:0] tx_words = '0;
    logic [1:0]   tx_slot;
    logic [63:0]  bus_data_n;
    logic [3:0]   bus_inv_n;
    logic         bus_ready_n, bus_busy_n;
    logic         rx_cap_en, rx_ready_n, rx_valid;
    logic [63:0]  rx_data_n;
    logic [3:0]   rx_inv_n;
    logic [255:0] rx_words;

    logic         loop = 1'b1;
    logic         m_cap = 1'b0, m_ready_n = 1'b1;
    logic [63:0]  m_data_n = '1;
    logic [3:0]   m_inv_n = '1;

    assign rx_cap_en  = loop ? 1'b1        : m_cap;
    assign rx_data_n  = loop ? bus_data_n  : m_data_n;
    assign rx_inv_n   = loop ? bus_inv_n   : m_inv_n;
    assign rx_ready_n = loop ? bus_ready_n : m_ready_n;

    qp_bus_port i_qp_bus_port (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_words(tx_words),
        .tx_slot(tx_slot), .bus_data_n(bus_data_n), .bus_inv_n(bus_inv_n),
        .bus_ready_n(bus_ready_n), .bus_busy_n(bus_busy_n),
        .rx_cap_en(rx_cap_en), .rx_data_n(rx_data_n), .rx_inv_n(rx_inv_n),
        .rx_ready_n(rx_ready_n), .rx_valid(rx_valid), .rx_words(rx_words)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // reference model state for the current cycle
    int           ph = 0;
    int           sub = 0;
    bit           act = 0, act_prev = 0, exp_val = 0;
    logic [255:0] cur = '0, ew = '0;
    logic [256:0] plan_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] actual, input logic [255:0] expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    function automatic logic [63:0] enc_pins(input logic [63:0] w);
        logic [63:0] r;
        for (int g = 0; g < 4; g++) begin
            r[g*16 +: 16] = ($countones(w[g*16 +: 16]) > 8) ? w[g*16 +: 16] : ~w[g*16 +: 16];
        end
        return r;
    endfunction

    function automatic logic [3:0] enc_flags(input logic [63:0] w);
        logic [3:0] f;
        for (int g = 0; g < 4; g++) f[g] = !($countones(w[g*16 +: 16]) > 8);
        return f;
    endfunction

    function automatic logic [63:0] dec(input logic [63:0] p, input logic [3:0] f);
        logic [63:0] r;
        for (int g = 0; g < 4; g++) r[g*16 +: 16] = f[g] ? ~p[g*16 +: 16] : p[g*16 +: 16];
        return r;
    endfunction

    task automatic step();
        logic [63:0] w, ep;
        logic [3:0]  ef;
        bit          nv;
        logic [256:0] e;
        w  = cur[sub*64 +: 64];
        ep = act ? enc_pins(w)  : '1;
        ef = act ? enc_flags(w) : 4'hF;
        chk(bus_data_n === ep, "R2 R3 R4 R6", "data lines", bus_data_n, ep);
        chk(bus_inv_n === ef, "R1 R3 R4", "flags", bus_inv_n, ef);
        for (int g = 0; g < 4; g++)
            chk($countones(~bus_data_n[g*16 +: 16]) <= 8, "R5", "low lines", bus_data_n, ep);
        if (act && w == 64'h0000_FFFF_01FF_00FF)
            chk(bus_inv_n === 4'b1001, "R1", "group map", bus_inv_n, 4'b1001);
        if (act && w == 64'h00FF_00FF_00FF_00FF)
            chk(bus_inv_n === 4'hF && bus_data_n === ~w, "R4", "eight ones", bus_data_n, ~w);
        if (act && w == '1)
            chk(bus_inv_n === 4'h0 && bus_data_n === '1, "R3", "all ones", bus_data_n, '1);
        chk(bus_ready_n === !act, "R7", "ready", bus_ready_n, !act);
        chk(bus_busy_n === !(act || act_prev), (act && act_prev) ? "R12" : "R7", "busy",
            bus_busy_n, !(act || act_prev));
        chk(tx_slot === 2'(ph), "R6", "slot", tx_slot, 2'(ph));
        if (loop) begin
            chk(rx_valid === exp_val, "R9", "rx valid", rx_valid, exp_val);
            if (exp_val) chk(rx_words === ew, "R8 R9", "rx words", rx_words, ew);
        end
        nv = loop && act && sub == 3;
        ew = cur;
        act_prev = act;
        if (ph == 3) begin
            tx_load = 1'b0;
            act = 0;
            if (plan_q.size() > 0) begin
                e = plan_q.pop_front();
                if (!e[256]) begin
                    tx_load = 1'b1; tx_words = e[255:0];
                    cur = e[255:0]; act = 1; sub = 0;
                end
            end
            if (!tx_load) tx_words = {8{$urandom}};
        end else begin
            tx_load  = (ph == 1);   // ignored outside slot 3 (R6)
            tx_words = {8{$urandom}};
            if (act) sub++;
        end
        ph = (ph + 1) % 4;
        exp_val = nv;
        @(negedge clk);
    endtask

    function automatic logic [255:0] rnd_frame();
        logic [255:0] f;
        for (int i = 0; i < 8; i++) f[i*32 +: 32] = $urandom;
        return f;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0]  a0, a1, a2, a3;
        logic [255:0] exp_rx;
        repeat (3) @(negedge clk);
        chk(bus_data_n === '1 && bus_inv_n === 4'hF, "R11", "reset lines", bus_data_n, '1);
        chk(bus_ready_n === 1'b1 && bus_busy_n === 1'b1, "R11", "reset ctl",
            {bus_ready_n, bus_busy_n}, 2'b11);
        chk(rx_valid === 1'b0 && tx_slot === 2'd0, "R11", "reset rx/slot", {rx_valid, tx_slot}, 0);
        rst_n = 1'b1;

        plan_q.push_back({1'b0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
                          64'h00FF_00FF_00FF_00FF, 64'h0000_FFFF_01FF_00FF});
        plan_q.push_back({1'b0, 64'h01FF_01FF_01FF_01FF, 64'hFFFF_0000_FFFF_0000,
                          64'h7FFF_FE00_8001_00FF, 64'h0123_4567_89AB_CDEF});
        for (int i = 0; i < 5; i++) plan_q.push_back({1'b0, rnd_frame()});
        plan_q.push_back({1'b1, 256'h0});
        plan_q.push_back({1'b1, 256'h0});
        for (int i = 0; i < 8; i++) begin
            plan_q.push_back({1'b0, rnd_frame()});
            if (i % 3 == 1) plan_q.push_back({1'b1, 256'h0});
        end
        while (plan_q.size() > 0) step();
        repeat (12) step();

        // directed receive sequence, transmit idle
        loop = 1'b0;
        a0 = 64'h1234_0000_FFFF_A5A5;
        a1 = 64'hDEAD_BEEF_0F0F_7777;
        a2 = 64'hCAFE_F00D_1111_8888;
        a3 = 64'h0001_8000_4242_E7E7;
        m_cap = 1'b1; m_ready_n = 1'b0; m_data_n = a0; m_inv_n = 4'hF; step();
        chk(rx_valid === 1'b0, "R9", "early valid", rx_valid, 0);
        m_data_n = a1; m_inv_n = 4'h0; step();
        m_ready_n = 1'b1; m_data_n = ~a3; step();
        chk(rx_valid === 1'b0, "R10", "not-ready capture", rx_valid, 0);
        m_cap = 1'b0; m_ready_n = 1'b0; m_data_n = a3; step();
        chk(rx_valid === 1'b0, "R10", "disabled capture", rx_valid, 0);
        m_cap = 1'b1; m_data_n = a2; m_inv_n = 4'b0101; step();
        chk(rx_valid === 1'b0, "R10", "count after skips", rx_valid, 0);
        m_data_n = a3; m_inv_n = 4'hF; step();
        exp_rx = {dec(a3, 4'hF), dec(a2, 4'b0101), dec(a1, 4'h0), dec(a0, 4'hF)};
        chk(rx_valid === 1'b1, "R10", "valid after four", rx_valid, 1);
        chk(rx_words === exp_rx, "R8", "restored words", rx_words, exp_rx);
        m_cap = 1'b0; m_ready_n = 1'b1; step();
        chk(rx_valid === 1'b0, "R9", "single pulse", rx_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule